// File: doc/BRIEF.md
# Parallel ADC interface controller

This block is the digital side of a 14-bit converter with a parallel output bus. A falling edge on the active-low convert-start input captures a raw signed sample from a stand-in data port and starts a conversion of fixed length. The busy output stays low while the conversion runs. At the end, a programmable two's complement offset is added to the raw sample. The sum can be clipped to the full-scale codes, and it is presented in offset-binary form with a separate overrange flag.

The result sits in an output register. That register is driven onto a shared tri-state bus while chip-select and read are both low. The same bus, with chip-select low, loads the offset register on the falling edge of a write pulse. A pipelining input chooses one of two behaviours. In the first, the result enters the output register when the conversion ends. In the second, the result is held back and enters the output register when the next conversion starts. All bus-side strobes pass through a two-flop synchroniser before edge detection, so each one acts three clock edges after it changes.

Top module: `pario_adc_if`

## Requirements
- R1: A falling edge on `convStN`, seen through the synchroniser, starts a conversion and captures `sampleIn` in the same cycle. `busyN` goes low no later than the third rising clock edge after `convStN` falls.
- R2: `busyN` stays low for exactly `CONV_CYCLES` clock cycles per conversion.
- R3: A falling edge on `convStN` while `busyN` is low is ignored. The busy length is unchanged and the sample captured at the start is the one converted.
- R4: With `pipeMode`=1, the new result is in the output register at the same clock edge where `busyN` returns high.
- R5: With `pipeMode`=0, `busyN` returns high when conversion ends but the output register keeps its previous value. The held result enters the output register at the next accepted conversion start.
- R6: `pipeMode` and `clipEn` are sampled only when a conversion starts. Changing them during a conversion has no effect on that conversion.
- R7: `dataBus` carries the output register only while synchronised `csN` and `rdN` are both low. Bit 14 is the overrange flag and bits 13..0 are the code, with bit 13 as the MSB.
- R8: With `csN` low and `rdN` high, the falling edge of a high pulse on `wrIn` loads `dataBus[13:0]` into the offset register. With `csN` high the pulse is ignored.
- R9: The sum S is raw + offset, both read as 14-bit two's complement. Without clipping, the code is (S + 8192) mod 16384, which is offset binary: 0x0000 is the most negative value and 0x3FFF is the most positive.
- R10: With clipping, S > 8191 gives code 0x3FFF and S < -8192 gives code 0x0000.
- R11: The overrange bit is 1 exactly when S lies outside -8192..8191, whether or not clipping is enabled.
- R12: `rstN` low, asynchronously and for as long as it is held, forces `busyN` high and abandons any conversion. It also clears the output register, the held result and the offset register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStN | input | 1 | Active-low convert-start strobe |
| csN | input | 1 | Active-low chip-select |
| rdN | input | 1 | Active-low read strobe |
| wrIn | input | 1 | Active-high offset write pulse |
| pipeMode | input | 1 | 1: load result at conversion end; 0: load at next start |
| clipEn | input | 1 | Enables clipping to full-scale codes |
| sampleIn | input | 14 | Raw signed sample (stand-in for the analog front end) |
| busyN | output | 1 | Low while a conversion runs |
| dataBus | inout | 15 | Tri-state bus: {overrange, code} out, offset word in |

## Verification
A stuck or misloaded conversion counter shows up directly at `busyN`: the low time differs from `CONV_CYCLES` within the same conversion. An offset register holding the wrong value, or a wrong clip or overflow decision, shows up in the first read-back after the conversion ends. The sweep covers offsets and samples at both range ends, so every such fault reaches the bus. A stale or lost held result in the deferred mode surfaces one conversion later, when the read-back shows either the previous word or a word that was never converted.

// File: rtl/pario_adc_pkg.sv
package pario_adc_pkg;
  typedef struct packed {
    logic start;   // accepted conversion start
    logic done;    // last busy cycle
    logic defer;   // result held until next start
    logic clip;    // clipping enabled for this conversion
    logic wrOff;   // load offset register from bus
  } ctrlStrobe_t;
endpackage

// File: rtl/pario_adc_ctrl.sv
module pario_adc_ctrl
  import pario_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 10,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        convStN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrIn,
  input  logic        pipeMode,
  input  logic        clipEn,
  output ctrlStrobe_t stb,
  output logic        busEn,
  output logic        busyN
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [3:0] SYNC_IDLE = 4'b0111; // {wr, rd, cs, conv}

  logic [3:0] syncQ [SYNC_DEPTH];
  logic [3:0] syncOut;
  logic convS, csS, rdS, wrS;
  logic prevConv, prevWr;
  logic convFall, wrFall, startOk, doneNow;
  logic busy, modeL, clipL;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncQ[k] <= SYNC_IDLE;
    end else begin
      syncQ[0] <= {wrIn, rdN, csN, convStN};
      for (int k = 1; k < SYNC_DEPTH; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  assign syncOut = syncQ[SYNC_DEPTH-1];
  assign convS = syncOut[0];
  assign csS   = syncOut[1];
  assign rdS   = syncOut[2];
  assign wrS   = syncOut[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevConv <= 1'b1;
      prevWr   <= 1'b0;
    end else begin
      prevConv <= convS;
      prevWr   <= wrS;
    end
  end

  assign convFall = prevConv & ~convS;
  assign wrFall   = prevWr & ~wrS;
  assign startOk  = convFall & ~busy;
  assign doneNow  = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      modeL <= 1'b1;
      clipL <= 1'b0;
    end else if (startOk) begin
      busy  <= 1'b1;
      cnt   <= CNT_LOAD;
      modeL <= pipeMode;
      clipL <= clipEn;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    stb.start = startOk;
    stb.done  = doneNow;
    stb.defer = ~modeL;
    stb.clip  = clipL;
    stb.wrOff = wrFall & ~csS;
  end

  assign busEn = ~csS & ~rdS;
  assign busyN = ~busy;

  a_r1_start_from_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(convFall));
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(modeL) && $stable(clipL)));
endmodule

// File: rtl/pario_adc_dp.sv
module pario_adc_dp
  import pario_adc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W:0]   outWord
);
  localparam int OUT_W = DATA_W + 1;

  logic [DATA_W-1:0] rawReg, offReg, code;
  logic [DATA_W:0]   sum;
  logic              over;
  logic [OUT_W-1:0]  result, outReg, pendReg;
  logic              pendValid;

  assign sum  = {rawReg[DATA_W-1], rawReg} + {offReg[DATA_W-1], offReg};
  assign over = sum[DATA_W] ^ sum[DATA_W-1];

  always_comb begin
    if (stb.clip && over) code = sum[DATA_W] ? '0 : '1;
    else                  code = {~sum[DATA_W-1], sum[DATA_W-2:0]};
  end

  assign result = {over, code};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawReg    <= '0;
      offReg    <= '0;
      outReg    <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
    end else begin
      if (stb.wrOff) offReg <= busIn;
      if (stb.start) begin
        rawReg <= sampleIn;
        if (pendValid) begin
          outReg    <= pendReg;
          pendValid <= 1'b0;
        end
      end else if (stb.done) begin
        if (stb.defer) begin
          pendReg   <= result;
          pendValid <= 1'b1;
        end else begin
          outReg <= result;
        end
      end
    end
  end

  assign outWord = outReg;

  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.start && !(stb.done && !stb.defer)) |=> $stable(outReg));
  a_r5_pend_taken: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> !pendValid);
endmodule

// File: rtl/pario_adc_if.sv
module pario_adc_if
  import pario_adc_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 10,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrIn,
  input  logic              pipeMode,
  input  logic              clipEn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busyN,
  inout  wire  [DATA_W:0]   dataBus
);
  ctrlStrobe_t     stb;
  logic            busEn;
  logic [DATA_W:0] outWord;

  pario_adc_ctrl #(.CONV_CYCLES(CONV_CYCLES), .SYNC_DEPTH(SYNC_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .convStN(convStN), .csN(csN), .rdN(rdN),
    .wrIn(wrIn), .pipeMode(pipeMode), .clipEn(clipEn),
    .stb(stb), .busEn(busEn), .busyN(busyN)
  );

  pario_adc_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleIn(sampleIn),
    .busIn(dataBus[DATA_W-1:0]), .outWord(outWord)
  );

  assign dataBus = busEn ? outWord : 'z;
endmodule

// File: tb/pario_adc_if_tb.sv
module pario_adc_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic convStN = 1'b1, csN = 1'b1, rdN = 1'b1, wrIn = 1'b0;
  logic pipeMode = 1'b1, clipEn = 1'b0;
  logic [13:0] sampleIn = '0;
  logic busyN;
  wire  [14:0] dataBus;
  logic tbDrv = 1'b0;
  logic [14:0] tbData = '0;
  int vecs = 0, errs = 0;
  bit finished = 0;

  assign dataBus = tbDrv ? tbData : 'z;
  always #(CLK_PERIOD/2) clk = ~clk;

  pario_adc_if #(.CONV_CYCLES(N)) dut_i (
    .clk(clk), .rstN(rstN), .convStN(convStN), .csN(csN), .rdN(rdN),
    .wrIn(wrIn), .pipeMode(pipeMode), .clipEn(clipEn), .sampleIn(sampleIn),
    .busyN(busyN), .dataBus(dataBus)
  );

  function automatic logic [14:0] model(int raw, int off, bit clip);
    int s = raw + off;
    bit ov = (s > 8191) || (s < -8192);
    int c;
    if (clip && s > 8191)       c = 16383;
    else if (clip && s < -8192) c = 0;
    else                        c = (s + 8192) & 16383;
    return {ov, 14'(c)};
  endfunction

  task automatic chk(string req, logic [14:0] act, logic [14:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readBus(output logic [14:0] v);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    v = dataBus;
    csN = 1'b1; rdN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic writeOff(int off, bit useCs);
    @(negedge clk); tbDrv = 1'b1; tbData = {1'b0, 14'(off)}; csN = !useCs;
    repeat (3) @(negedge clk); wrIn = 1'b1;
    repeat (4) @(negedge clk); wrIn = 1'b0;
    repeat (4) @(negedge clk); tbDrv = 1'b0; csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // starts a conversion, returns edges until busy and busy-low length
  task automatic convert(int raw, output int lat, output int len);
    @(negedge clk); sampleIn = 14'(raw); convStN = 1'b0;
    lat = 0;
    while (busyN && lat < 20) begin @(negedge clk); lat++; end
    len = 0;
    while (!busyN && len < 100) begin len++; @(negedge clk); end
    convStN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  int offs[6] = '{0, 1, -1, 8191, -8192, 1234};
  int raws[7] = '{0, 8191, -8192, 1, -1, 5000, -5000};

  initial begin
    logic [14:0] v, lastOut;
    int lat, len;
    repeat (3) @(negedge clk);
    chk("R12 busy in reset", {14'd0, busyN}, 15'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    readBus(v); chk("R12 output reg reset", v, 15'd0);

    // R9 R10 R11 R2 R1 R7 R4: sweep in end-of-conversion mode
    pipeMode = 1'b1;
    foreach (offs[i]) begin
      writeOff(offs[i], 1'b1);   // R8
      foreach (raws[j]) begin
        for (int c = 0; c < 2; c++) begin
          clipEn = c[0];
          convert(raws[j], lat, len);
          chk("R1 start latency", 15'(lat <= 3), 15'd1);
          chk("R2 busy length", 15'(len), 15'(N));
          readBus(v);
          chk("R9/R10/R11 result R4", v, model(raws[j], offs[i], c[0]));
        end
      end
    end

    // R8: write with chip-select high ignored
    writeOff(0, 1'b1);
    writeOff(500, 1'b0);
    clipEn = 1'b0;
    convert(100, lat, len);
    readBus(v); chk("R8 write ignored cs high", v, model(100, 0, 0));

    // R6: modes sampled only at start
    writeOff(1000, 1'b1);
    pipeMode = 1'b1; clipEn = 1'b1;
    @(negedge clk); sampleIn = 14'd8000; convStN = 1'b0;
    while (busyN) @(negedge clk);
    pipeMode = 1'b0; clipEn = 1'b0;
    while (!busyN) @(negedge clk);
    convStN = 1'b1; repeat (4) @(negedge clk);
    readBus(v); chk("R6 mode held", v, model(8000, 1000, 1));
    lastOut = v;

    // R5: deferred load
    writeOff(0, 1'b1);
    pipeMode = 1'b0; clipEn = 1'b0;
    convert(100, lat, len);
    chk("R5 busy length", 15'(len), 15'(N));
    readBus(v); chk("R5 output held", v, lastOut);
    convert(200, lat, len);
    readBus(v); chk("R5 loaded on next start", v, model(100, 0, 0));
    pipeMode = 1'b1;
    convert(300, lat, len);
    readBus(v); chk("R5 then R4 load", v, model(300, 0, 0));

    // R3: edge during busy ignored
    @(negedge clk); sampleIn = 14'd777; convStN = 1'b0;
    lat = 0;
    while (busyN) begin @(negedge clk); lat++; end
    convStN = 1'b1;
    len = 0;
    repeat (3) begin len++; @(negedge clk); end
    sampleIn = 14'd42; convStN = 1'b0;
    while (!busyN) begin len++; @(negedge clk); end
    chk("R3 busy length unchanged", 15'(len), 15'(N));
    repeat (6) @(negedge clk);
    chk("R3 no restart", {14'd0, busyN}, 15'd1);
    convStN = 1'b1; repeat (4) @(negedge clk);
    readBus(v); chk("R3 original sample", v, model(777, 0, 0));

    // R12: reset aborts and clears
    writeOff(300, 1'b1);
    @(negedge clk); sampleIn = 14'd5; convStN = 1'b0;
    while (busyN) @(negedge clk);
    repeat (2) @(negedge clk);
    rstN = 1'b0; #1;
    chk("R12 async abort", {14'd0, busyN}, 15'd1);
    convStN = 1'b1;
    repeat (2) @(negedge clk); convStN = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 held in reset", {14'd0, busyN}, 15'd1);
    convStN = 1'b1; @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 idle after reset", {14'd0, busyN}, 15'd1);
    readBus(v); chk("R12 output cleared", v, 15'd0);
    convert(-20, lat, len);
    readBus(v); chk("R12 offset cleared", v, model(-20, 0, 0));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule